// File: doc/BRIEF.md
# Vertical Stripe Test Pattern Source

This block produces a synthetic byte stream of vertical colour bands for a video-mode display link. When it is selected it takes the place of the normal pixel input. The normal input is held off and its data never reaches the output, so the downstream sequencer sees only generated bytes. Each band is a power of two pixels wide, and the bands alternate between two programmable 24-bit colours. Pixels go out either as three bytes (blue, green, red) or as a two-byte 5-6-5 word. The line length in bytes and the number of lines per frame are both programmable.

A two-state machine controls the generator. In IDLE no generated byte is offered. The START transition leads to EMIT when the generator is selected and the run input is high. EMIT holds while bytes flow and runs the WRAP transition from the last byte of a frame back to line 0 while run stays high. EMIT returns to IDLE on one of four transitions. DESELECT happens when the select input drops. ABORT happens when stop setting 0 is in force and run is low. LINE_STOP happens at a line end under stop setting 1 with run low. FRAME_STOP happens at a frame end under stop setting 2 or 3 with run low. The counters stay cleared in IDLE, so every start begins at line 0, pixel 0.

Top module: `vstripe_src`

## Requirements
- R1: After reset the machine is in IDLE. While selected and not running, out_valid stays low.
- R2: With gen_sel high, run sampled high in IDLE offers the first byte (line 0, byte 0, out_sol=1) in the following cycle.
- R3: Pixel p of a line uses col_a when floor(p / 2^stripe_exp) is even and col_b when it is odd. The pixel count restarts at 0 on every line. Colours are {red[23:16], green[15:8], blue[7:0]}.
- R4: With fmt16=0 each pixel is three bytes in the order blue, green, red.
- R5: With fmt16=1 each pixel is two bytes. The first is {green[4:2], blue[7:3]} and the second is {red[7:3], green[7:5]}.
- R6: A line holds line_bytes bytes and a frame holds line_count lines (both at least 1). out_sol marks the first byte of each line. out_eof marks only the last byte of the last line.
- R7: A byte is consumed only when out_valid and out_ready are both high. While out_ready is low the offered byte holds and no counter moves.
- R8: With gen_sel=0 the input stream passes straight through, and in_ready equals out_ready. With gen_sel=1, in_ready is 0 and input bytes never appear at the output.
- R9: Stop setting 0: once run is low in EMIT, out_valid drops in the same cycle and the machine returns to IDLE. A later start begins again at line 0, byte 0.
- R10: Stop setting 1: with run low, the current line completes and then the machine returns to IDLE.
- R11: Stop settings 2 and 3: with run low, the current frame completes and then the machine returns to IDLE. While run stays high, a new frame follows at once from line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gen_sel | input | 1 | Selects the generator instead of the input stream |
| gen_run | input | 1 | Run request |
| stop_mode | input | 2 | 0 abort, 1 end of line, 2/3 end of frame |
| fmt16 | input | 1 | 1: 5-6-5 two-byte pixels, 0: three-byte pixels |
| stripe_exp | input | EW (4) | Band width exponent |
| col_a | input | 24 | First band colour {R,G,B} |
| col_b | input | 24 | Second band colour {R,G,B} |
| line_count | input | LW (12) | Lines per frame |
| line_bytes | input | BW (16) | Bytes per line |
| in_data | input | 8 | Normal stream byte |
| in_valid | input | 1 | Normal stream valid |
| in_sol | input | 1 | Normal stream start of line |
| in_eof | input | 1 | Normal stream end of frame |
| in_ready | output | 1 | Ready toward the normal stream |
| out_data | output | 8 | Output byte |
| out_valid | output | 1 | Output valid |
| out_sol | output | 1 | Output start-of-line marker |
| out_eof | output | 1 | Output end-of-frame marker |
| out_ready | input | 1 | Downstream ready |

## Verification
Several properties are checked on every cycle: the byte and line counters stay inside the programmed frame while in EMIT, a stalled byte stays unchanged, the normal input is refused while the generator is selected, and no byte is offered in IDLE or while an abort condition holds. The exact band colours, byte order, marker placement and the point where each stop setting ends the stream are shown only by the bench's scenarios. In those scenarios every consumed byte is compared against a stream computed from the programmed settings.

// File: rtl/vstripe_pkg.sv
package vstripe_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } gen_state_t;

    localparam logic [1:0] STOP_NOW  = 2'd0;
    localparam logic [1:0] STOP_LINE = 2'd1;

    typedef struct packed {
        logic [7:0] data;
        logic       sol;
        logic       eof;
    } beat_t;

endpackage

// File: rtl/vstripe_pos.sv
module vstripe_pos #(
    parameter int BW = 16,
    parameter int LW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic          fmt16,
    input  logic [BW-1:0] line_bytes,
    input  logic [LW-1:0] line_count,
    output logic [BW-1:0] byte_idx,
    output logic [BW-1:0] pix_idx,
    output logic [1:0]    sub_idx,
    output logic [LW-1:0] line_idx,
    output logic          line_last,
    output logic          frame_last
);
    localparam logic [BW-1:0] ONE_B = BW'(1);
    localparam logic [LW-1:0] ONE_L = LW'(1);

    logic [1:0] sub_last;

    always_comb begin
        sub_last   = fmt16 ? 2'd1 : 2'd2;
        line_last  = (byte_idx == line_bytes - ONE_B);
        frame_last = line_last && (line_idx == line_count - ONE_L);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_idx <= '0;
            pix_idx  <= '0;
            sub_idx  <= '0;
            line_idx <= '0;
        end else if (clear) begin
            byte_idx <= '0;
            pix_idx  <= '0;
            sub_idx  <= '0;
            line_idx <= '0;
        end else if (step) begin
            if (line_last) begin
                byte_idx <= '0;
                pix_idx  <= '0;
                sub_idx  <= '0;
                line_idx <= frame_last ? '0 : line_idx + ONE_L;
            end else begin
                byte_idx <= byte_idx + ONE_B;
                if (sub_idx == sub_last) begin
                    sub_idx <= '0;
                    pix_idx <= pix_idx + ONE_B;
                end else begin
                    sub_idx <= sub_idx + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/vstripe_pix.sv
module vstripe_pix #(
    parameter int BW = 16,
    parameter int EW = 4
) (
    input  logic [BW-1:0] pix_idx,
    input  logic [1:0]    sub_idx,
    input  logic [EW-1:0] stripe_exp,
    input  logic          fmt16,
    input  logic [23:0]   col_a,
    input  logic [23:0]   col_b,
    output logic [7:0]    byte_out
);
    logic [BW-1:0] band;
    logic [23:0]   col;
    logic [7:0]    red, grn, blu;

    always_comb begin
        band = pix_idx >> stripe_exp;
        col  = band[0] ? col_b : col_a;
        red  = col[23:16];
        grn  = col[15:8];
        blu  = col[7:0];
        if (fmt16) begin
            byte_out = (sub_idx == 2'd0) ? {grn[4:2], blu[7:3]} : {red[7:3], grn[7:5]};
        end else begin
            unique case (sub_idx)
                2'd0:    byte_out = blu;
                2'd1:    byte_out = grn;
                default: byte_out = red;
            endcase
        end
    end
endmodule

// File: rtl/vstripe_mux.sv
module vstripe_mux
    import vstripe_pkg::*;
(
    input  logic  gen_sel,
    input  beat_t gen_beat,
    input  logic  gen_valid,
    output logic  gen_ready,
    input  beat_t in_beat,
    input  logic  in_valid,
    output logic  in_ready,
    output beat_t out_beat,
    output logic  out_valid,
    input  logic  out_ready
);
    always_comb begin
        if (gen_sel) begin
            out_beat  = gen_beat;
            out_valid = gen_valid;
            gen_ready = out_ready;
            in_ready  = 1'b0;
        end else begin
            out_beat  = in_beat;
            out_valid = in_valid;
            gen_ready = 1'b0;
            in_ready  = out_ready;
        end
    end
endmodule

// File: rtl/vstripe_src.sv
module vstripe_src
    import vstripe_pkg::*;
#(
    parameter int BW = 16,
    parameter int LW = 12,
    parameter int EW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gen_sel,
    input  logic          gen_run,
    input  logic [1:0]    stop_mode,
    input  logic          fmt16,
    input  logic [EW-1:0] stripe_exp,
    input  logic [23:0]   col_a,
    input  logic [23:0]   col_b,
    input  logic [LW-1:0] line_count,
    input  logic [BW-1:0] line_bytes,
    input  logic [7:0]    in_data,
    input  logic          in_valid,
    input  logic          in_sol,
    input  logic          in_eof,
    output logic          in_ready,
    output logic [7:0]    out_data,
    output logic          out_valid,
    output logic          out_sol,
    output logic          out_eof,
    input  logic          out_ready
);
    gen_state_t state, state_nx;

    logic [BW-1:0] byte_idx, pix_idx;
    logic [1:0]    sub_idx;
    logic [LW-1:0] line_idx;
    logic          line_last, frame_last;
    logic          abort_now, gen_valid, gen_ready, fire;
    logic [7:0]    pix_byte;
    beat_t         gen_beat, in_beat, out_beat;

    always_comb begin
        abort_now = (stop_mode == STOP_NOW) && !gen_run;
        gen_valid = (state == ST_EMIT) && !abort_now;
        fire      = gen_valid && gen_ready;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: START, DESELECT, ABORT, LINE_STOP, FRAME_STOP, WRAP
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (gen_sel && gen_run) state_nx = ST_EMIT;
            end
            ST_EMIT: begin
                if (!gen_sel)                            state_nx = ST_IDLE;
                else if (abort_now)                      state_nx = ST_IDLE;
                else if (fire && line_last && !gen_run) begin
                    if (frame_last || stop_mode == STOP_LINE) state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    vstripe_pos #(.BW(BW), .LW(LW)) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (state == ST_IDLE),
        .step       (fire),
        .fmt16      (fmt16),
        .line_bytes (line_bytes),
        .line_count (line_count),
        .byte_idx   (byte_idx),
        .pix_idx    (pix_idx),
        .sub_idx    (sub_idx),
        .line_idx   (line_idx),
        .line_last  (line_last),
        .frame_last (frame_last)
    );

    vstripe_pix #(.BW(BW), .EW(EW)) u_pix (
        .pix_idx    (pix_idx),
        .sub_idx    (sub_idx),
        .stripe_exp (stripe_exp),
        .fmt16      (fmt16),
        .col_a      (col_a),
        .col_b      (col_b),
        .byte_out   (pix_byte)
    );

    // output assembly
    always_comb begin
        gen_beat.data = pix_byte;
        gen_beat.sol  = (byte_idx == '0);
        gen_beat.eof  = frame_last;
        in_beat.data  = in_data;
        in_beat.sol   = in_sol;
        in_beat.eof   = in_eof;
        out_data      = out_beat.data;
        out_sol       = out_beat.sol;
        out_eof       = out_beat.eof;
    end

    vstripe_mux u_mux (
        .gen_sel   (gen_sel),
        .gen_beat  (gen_beat),
        .gen_valid (gen_valid),
        .gen_ready (gen_ready),
        .in_beat   (in_beat),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .out_beat  (out_beat),
        .out_valid (out_valid),
        .out_ready (out_ready)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_sel && state == ST_IDLE) |-> !out_valid);
    // R6
    line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && line_count != '0) |-> (line_idx < line_count));
    // R6
    byte_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMIT && line_bytes != '0) |-> (byte_idx < line_bytes));
    // R7
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_sel && out_valid && !out_ready) |=> (!out_valid || !gen_sel || $stable(out_data)));
    // R8
    input_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_sel |-> !in_ready);
    // R9
    abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_sel && stop_mode == STOP_NOW && !gen_run) |-> !out_valid);
endmodule

// File: tb/vstripe_src_bench.sv
module vstripe_src_bench;
    localparam int BW = 16;
    localparam int LW = 12;
    localparam int EW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gen_sel = 1'b0, gen_run = 1'b0, fmt16 = 1'b0;
    logic [1:0]    stop_mode = 2'd2;
    logic [EW-1:0] stripe_exp = '0;
    logic [23:0]   col_a = '0, col_b = '0;
    logic [LW-1:0] line_count = LW'(1);
    logic [BW-1:0] line_bytes = BW'(3);
    logic [7:0]    in_data = '0;
    logic          in_valid = 1'b0, in_sol = 1'b0, in_eof = 1'b0;
    logic          in_ready, out_valid, out_sol, out_eof;
    logic [7:0]    out_data;
    logic          out_ready = 1'b1;

    int   total = 0, bad = 0, cyc = 0, eof_cnt = 0;
    logic bp_en = 1'b0;
    logic [9:0] q[$];

    always #10 clk = ~clk;

    vstripe_src #(.BW(BW), .LW(LW), .EW(EW)) u_vstripe_src (
        .clk(clk), .rst_n(rst_n), .gen_sel(gen_sel), .gen_run(gen_run),
        .stop_mode(stop_mode), .fmt16(fmt16), .stripe_exp(stripe_exp),
        .col_a(col_a), .col_b(col_b), .line_count(line_count),
        .line_bytes(line_bytes), .in_data(in_data), .in_valid(in_valid),
        .in_sol(in_sol), .in_eof(in_eof), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_sol(out_sol),
        .out_eof(out_eof), .out_ready(out_ready)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_byte(input int pos);
        int bpp, px, sub;
        logic [23:0] c;
        bpp = fmt16 ? 2 : 3;
        px  = pos / bpp;
        sub = pos % bpp;
        c   = (((px >> stripe_exp) & 1) == 1) ? col_b : col_a;
        if (fmt16)
            return (sub == 0) ? {c[12:10], c[7:3]} : {c[23:19], c[15:13]};
        case (sub)
            0:       return c[7:0];
            1:       return c[15:8];
            default: return c[23:16];
        endcase
    endfunction

    // driver: queue the expected beats of nl lines
    task automatic push_lines(input int nl, input logic full_frame);
        for (int l = 0; l < nl; l++)
            for (int b = 0; b < int'(line_bytes); b++)
                q.push_back({ref_byte(b), b == 0,
                    full_frame && (l == int'(line_count) - 1) && (b == int'(line_bytes) - 1)});
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic drain();
        while (q.size() != 0) @(posedge clk);
        tick(6);
        chk(q.size() == 0, "R6 queue left", q.size(), 0);
    endtask

    // monitor
    always @(negedge clk) begin
        logic [9:0] e;
        cyc++;
        out_ready = bp_en ? ((cyc % 3) != 1) : 1'b1;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL R2 watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        if (gen_sel && out_valid && out_ready) begin
            if (q.size() == 0) begin
                chk(1'b0, "R6 unexpected byte", out_data, 0);
            end else begin
                e = q.pop_front();
                // R3 R4 R5 R6 R7 R8: bytes and markers match the computed stream
                chk({out_data, out_sol, out_eof} == e, "R6 stream", {out_data, out_sol, out_eof}, e);
                if (e[0]) eof_cnt++;
            end
        end
    end

    initial begin
        tick(3);
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
        rst_n = 1'b1;
        gen_sel = 1'b1; in_valid = 1'b1; in_data = 8'h77;
        tick(2);
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R1 idle valid", out_valid, 0);
        chk(in_ready == 1'b0, "R8 in_ready blocked", in_ready, 0);

        // passthrough
        gen_sel = 1'b0; in_data = 8'h5A; in_sol = 1'b1;
        @(negedge clk); #1;
        chk(out_valid == 1'b1 && out_data == 8'h5A && out_sol == 1'b1, "R8 passthrough",
            {out_valid, out_data}, {1'b1, 8'h5A});
        chk(in_ready == out_ready, "R8 ready follows", in_ready, out_ready);
        in_sol = 1'b0;

        // frame, 24-bit, stripes of 2, stop at frame end
        tick(1);
        gen_sel = 1'b1; fmt16 = 1'b0; stripe_exp = 4'd1;
        col_a = 24'hFF0000; col_b = 24'h00FF00;
        line_bytes = BW'(18); line_count = LW'(3); stop_mode = 2'd2;
        push_lines(3, 1'b1);
        gen_run = 1'b1;
        tick(1);
        gen_run = 1'b0;
        @(negedge clk); #1;
        // R2 first byte one cycle after start
        chk(out_valid && out_sol, "R2 first byte", {out_valid, out_sol}, 2'b11);
        chk(in_ready == 1'b0, "R8 blocked while running", in_ready, 0);
        drain();
        // R11 stopped after frame
        chk(out_valid == 1'b0, "R11 idle after frame", out_valid, 0);

        // 16-bit with backpressure
        fmt16 = 1'b1; stripe_exp = 4'd0; col_a = 24'h123456; col_b = 24'hABCDEF;
        line_bytes = BW'(8); line_count = LW'(2); bp_en = 1'b1;
        push_lines(2, 1'b1);
        gen_run = 1'b1; tick(1); gen_run = 1'b0;
        drain();
        bp_en = 1'b0;

        // R10 stop at end of line
        fmt16 = 1'b0; stripe_exp = 4'd2; line_bytes = BW'(9); line_count = LW'(4);
        stop_mode = 2'd1;
        push_lines(1, 1'b0);
        gen_run = 1'b1; tick(2); gen_run = 1'b0;
        drain();
        chk(out_valid == 1'b0, "R10 idle after line", out_valid, 0);

        // R9 abort
        stop_mode = 2'd0;
        push_lines(4, 1'b1);
        gen_run = 1'b1; tick(4); gen_run = 1'b0;
        @(negedge clk); #1;
        chk(out_valid == 1'b0, "R9 abort drops valid", out_valid, 0);
        tick(3);
        chk(out_valid == 1'b0, "R9 stays idle", out_valid, 0);
        q.delete();
        stop_mode = 2'd2;
        push_lines(4, 1'b1);
        gen_run = 1'b1; tick(1); gen_run = 1'b0;
        drain();   // R9 restart from line 0

        // R11 continuous frames, wide stripe all col_a
        stop_mode = 2'd3; stripe_exp = 4'd6; line_bytes = BW'(6); line_count = LW'(2);
        eof_cnt = 0;
        push_lines(2, 1'b1);
        push_lines(2, 1'b1);
        gen_run = 1'b1;
        wait (eof_cnt == 1);
        tick(1);
        gen_run = 1'b0;
        drain();
        chk(eof_cnt == 2, "R11 two frames", eof_cnt, 2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule